// File: doc/BRIEF.md
# Simultaneous-Sampling ADC Host Controller

This block sits between on-chip logic and a six-channel serial converter that samples all of its inputs at one instant. A user request starts one conversion frame. The controller puts the channel-count code and the input-range line on the converter pins, waits out an acquisition interval when the range has changed, and raises the convert strobe. It then generates the serial clock for sixteen periods per active channel. Each active channel's result comes back tagged with its channel index, sign-extended for bipolar range and zero-extended for unipolar range.

The converter sends the results of a conversion during the conversion that follows it. The controller tracks whether the previous frame used the same settings and whether a power-down came in between. When the data in a frame is stale or mismatched, the controller withholds it. A power-down request sends a burst of convert pulses with the serial clock held low. Two pulses select light power-down and four select deep power-down. The next start request sends one serial clock pulse to wake the converter before the frame begins.

Top module: `adc_ctl`

## Requirements
- R1: A select code s gives min(s+1, 6) results per valid frame, so codes 5, 6 and 7 all give six. The results carry channel indices 0, 1, 2 and so on in ascending order.
- R2: Each frame has exactly one convert rising edge, followed by exactly 16 serial clock rising edges per active channel. Both lines are low whenever `busy` is low.
- R3: Each 16-bit slot arrives MSB first. The 14-bit result occupies slot positions 2 to 15 and the first two bits are ignored. Data is sampled at the falling edge of the generated serial clock.
- R4: Results delivered in frame k are the samples taken by conversion k-1. The first frame after reset produces no results. So does the first frame after a change of select code or range, and the first frame after a wake-up.
- R5: The select and range pins change only at the acceptance of a start request. They stay constant from then until the frame ends.
- R6: When the range setting changes, at least ACQ_CYC clock cycles pass from the range pin change to the next convert rising edge.
- R7: In bipolar range (range pin 1) the result is the 14-bit two's-complement value sign-extended to 16 bits. In unipolar range (range pin 0) it is zero-extended.
- R8: A light power-down request gives exactly 2 convert pulses and a deep request gives exactly 4, with the serial clock low throughout. `dozing` is then high. A power-down request while dozing has no effect.
- R9: A start request while dozing gives exactly one serial clock pulse before the convert strobe. At least ACQ_CYC cycles pass from that pulse to the convert rising edge.
- R10: A start request while `busy` is high is ignored. It starts no frame and changes no pin setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one conversion frame |
| cfg_sel | input | 3 | Channel-count code for the requested frame |
| cfg_bip | input | 1 | Range for the requested frame: 1 bipolar, 0 unipolar |
| pd_req | input | 1 | Request power-down |
| pd_deep | input | 1 | With pd_req: 1 deep, 0 light |
| busy | output | 1 | Frame, wake or power-down sequence in progress |
| dozing | output | 1 | Converter is powered down |
| res_valid | output | 1 | One-cycle result strobe |
| res_chan | output | 3 | Channel index of the result |
| res_data | output | 16 | Extended result |
| adc_conv | output | 1 | Convert strobe to converter |
| adc_sck | output | 1 | Serial clock to converter |
| adc_sel | output | 3 | Channel-count code to converter |
| adc_bip | output | 1 | Range line to converter |
| adc_sdo | input | 1 | Serial data from converter |

## Verification
A result is due on the clock after the sample edge that completes its slot, which is the falling serial clock edge ending bit 15 of that slot. The bench therefore reads `res_valid` at falling core-clock edges, which always lie between that registered update and the next one. Pin-level counts are checked once `busy` has been low for two cycles, after the frame has fully ended. These counts are serial clock pulses per frame, convert pulses per power-down and wake pulses. The acquisition gaps are measured in time from the pin change to the convert edge and compared with ACQ_CYC periods.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ACQ,
    S_CONV,
    S_SHIFT,
    S_PDN,
    S_DOWN,
    S_WAKE
  } seq_st_t;
endpackage

// File: rtl/adc_ctl_chancount.sv
module adc_ctl_chancount #(
  parameter int NCH   = 6,
  parameter int SEL_W = 3,
  parameter int CNT_W = 3
) (
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] nch
);
  // saturating map from select code to number of active channels
  always_comb begin
    if (32'(sel) >= NCH - 1) nch = CNT_W'(NCH);
    else                     nch = CNT_W'(32'(sel) + 1);
  end
endmodule

// File: rtl/adc_ctl_capture.sv
module adc_ctl_capture #(
  parameter int SLOT_W = 16,
  parameter int RES_W  = 14,
  parameter int LEAD   = 2,
  parameter int OUT_W  = 16,
  parameter int POS_W  = 4,
  parameter int CH_W   = 3,
  parameter int BIT_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             samp,
  input  logic             sdo,
  input  logic [BIT_W-1:0] bit_idx,
  input  logic             keep,
  input  logic             bip,
  output logic             res_valid,
  output logic [CH_W-1:0]  res_chan,
  output logic [OUT_W-1:0] res_data
);
  localparam int EXT_W = OUT_W - RES_W;

  logic [SLOT_W-2:0] shreg;
  logic [SLOT_W-1:0] word;
  logic [RES_W-1:0]  field;
  logic              slot_end;
  logic              valid_n;
  logic [OUT_W-1:0]  data_n;

  assign word     = {shreg, sdo};
  assign field    = word[SLOT_W-1-LEAD -: RES_W];
  assign slot_end = samp && (bit_idx[POS_W-1:0] == {POS_W{1'b1}});

  always_comb begin
    valid_n = slot_end && keep;
    if (bip) data_n = {{EXT_W{field[RES_W-1]}}, field};
    else     data_n = {{EXT_W{1'b0}}, field};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      res_valid <= 1'b0;
      res_chan  <= '0;
      res_data  <= '0;
    end else begin
      res_valid <= valid_n;
      if (samp) shreg <= word[SLOT_W-2:0];
      if (slot_end) begin
        res_chan <= bit_idx[BIT_W-1:POS_W];
        res_data <= data_n;
      end
    end
  end
endmodule

// File: rtl/adc_ctl_seq.sv
module adc_ctl_seq
  import adc_ctl_pkg::*;
#(
  parameter int NCH          = 6,
  parameter int SEL_W        = 3,
  parameter int CNT_W        = 3,
  parameter int POS_W        = 4,
  parameter int CH_W         = 3,
  parameter int BIT_W        = 7,
  parameter int ACQ_CYC      = 20,
  parameter int CONV_HI      = 2,
  parameter int NAP_PULSES   = 2,
  parameter int SLEEP_PULSES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic             cfg_bip,
  input  logic             pd_req,
  input  logic             pd_deep,
  input  logic [CNT_W-1:0] nch,
  output logic             conv,
  output logic             sck,
  output logic             samp,
  output logic [BIT_W-1:0] bit_idx,
  output logic [SEL_W-1:0] sel,
  output logic             bip,
  output logic             keep,
  output logic             busy,
  output logic             dozing
);
  localparam int PD_MAX   = 2 * SLEEP_PULSES;
  localparam int W1       = (ACQ_CYC > PD_MAX) ? ACQ_CYC : PD_MAX;
  localparam int WAIT_MAX = (W1 > CONV_HI) ? W1 : CONV_HI;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);

  seq_st_t          st, st_n;
  logic [WAIT_W-1:0] wcnt, wcnt_n;
  logic             sck_q, sck_n, conv_q, conv_n, ph, ph_n;
  logic [SEL_W-1:0] sel_q, sel_n;
  logic             bip_q, bip_n, prev_ok, ok_n, keep_q, keep_n;
  logic [BIT_W-1:0] bcnt, bcnt_n;
  logic             last_bit;

  assign last_bit = (bcnt[POS_W-1:0] == {POS_W{1'b1}}) &&
                    (bcnt[BIT_W-1:POS_W] == CH_W'(nch - 1'b1));

  always_comb begin
    st_n   = st;     wcnt_n = wcnt;   sck_n  = sck_q;  conv_n = conv_q;
    sel_n  = sel_q;  bip_n  = bip_q;  bcnt_n = bcnt;   ph_n   = ph;
    ok_n   = prev_ok; keep_n = keep_q;
    case (st)
      S_IDLE: begin
        if (start) begin
          sel_n  = cfg_sel;
          bip_n  = cfg_bip;
          keep_n = prev_ok && (cfg_sel == sel_q) && (cfg_bip == bip_q);
          st_n   = S_ACQ;
          wcnt_n = (cfg_bip != bip_q) ? WAIT_W'(ACQ_CYC - 1) : '0;
        end else if (pd_req) begin
          st_n   = S_PDN;
          conv_n = 1'b1;
          ok_n   = 1'b0;
          wcnt_n = pd_deep ? WAIT_W'(2 * SLEEP_PULSES - 1) : WAIT_W'(2 * NAP_PULSES - 1);
        end
      end
      S_ACQ: begin
        if (wcnt == '0) begin
          st_n   = S_CONV;
          conv_n = 1'b1;
          wcnt_n = WAIT_W'(CONV_HI - 1);
        end else wcnt_n = wcnt - 1'b1;
      end
      S_CONV: begin
        if (wcnt == '0) begin
          st_n   = S_SHIFT;
          conv_n = 1'b0;
          bcnt_n = '0;
          ph_n   = 1'b0;
        end else wcnt_n = wcnt - 1'b1;
      end
      S_SHIFT: begin
        if (!ph) begin
          sck_n = 1'b1;
          ph_n  = 1'b1;
        end else begin
          sck_n  = 1'b0;
          ph_n   = 1'b0;
          bcnt_n = bcnt + 1'b1;
          if (last_bit) begin
            st_n = S_IDLE;
            ok_n = 1'b1;
          end
        end
      end
      S_PDN: begin
        if (wcnt == '0) begin
          st_n   = S_DOWN;
          conv_n = 1'b0;
        end else begin
          wcnt_n = wcnt - 1'b1;
          conv_n = ~conv_q;
        end
      end
      S_DOWN: begin
        if (start) begin
          sel_n  = cfg_sel;
          bip_n  = cfg_bip;
          keep_n = 1'b0;
          sck_n  = 1'b1;
          st_n   = S_WAKE;
        end
      end
      S_WAKE: begin
        if (sck_q) sck_n = 1'b0;
        else begin
          st_n   = S_ACQ;
          wcnt_n = WAIT_W'(ACQ_CYC - 1);
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      wcnt    <= '0;
      sck_q   <= 1'b0;
      conv_q  <= 1'b0;
      sel_q   <= '0;
      bip_q   <= 1'b0;
      bcnt    <= '0;
      ph      <= 1'b0;
      prev_ok <= 1'b0;
      keep_q  <= 1'b0;
    end else begin
      st      <= st_n;
      wcnt    <= wcnt_n;
      sck_q   <= sck_n;
      conv_q  <= conv_n;
      sel_q   <= sel_n;
      bip_q   <= bip_n;
      bcnt    <= bcnt_n;
      ph      <= ph_n;
      prev_ok <= ok_n;
      keep_q  <= keep_n;
    end
  end

  assign conv    = conv_q;
  assign sck     = sck_q;
  assign samp    = (st == S_SHIFT) && ph;
  assign bit_idx = bcnt;
  assign sel     = sel_q;
  assign bip     = bip_q;
  assign keep    = keep_q;
  assign busy    = (st != S_IDLE) && (st != S_DOWN);
  assign dozing  = (st == S_DOWN);
endmodule

// File: rtl/adc_ctl.sv
module adc_ctl #(
  parameter int NCH          = 6,
  parameter int SEL_W        = 3,
  parameter int SLOT_W       = 16,
  parameter int RES_W        = 14,
  parameter int LEAD         = 2,
  parameter int OUT_W        = 16,
  parameter int ACQ_CYC      = 20,
  parameter int CONV_HI      = 2,
  parameter int NAP_PULSES   = 2,
  parameter int SLEEP_PULSES = 4,
  localparam int CH_W        = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic             cfg_bip,
  input  logic             pd_req,
  input  logic             pd_deep,
  output logic             busy,
  output logic             dozing,
  output logic             res_valid,
  output logic [CH_W-1:0]  res_chan,
  output logic [OUT_W-1:0] res_data,
  output logic             adc_conv,
  output logic             adc_sck,
  output logic [SEL_W-1:0] adc_sel,
  output logic             adc_bip,
  input  logic             adc_sdo
);
  localparam int CNT_W = $clog2(NCH + 1);
  localparam int POS_W = $clog2(SLOT_W);
  localparam int BIT_W = POS_W + CH_W;

  logic [1:0]       rsync;
  logic             rst_core_n;
  logic [CNT_W-1:0] nch;
  logic             samp, keep;
  logic [BIT_W-1:0] bit_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_core_n = rsync[1];

  adc_ctl_chancount #(.NCH(NCH), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_count (
    .sel (adc_sel),
    .nch (nch)
  );

  adc_ctl_seq #(
    .NCH(NCH), .SEL_W(SEL_W), .CNT_W(CNT_W), .POS_W(POS_W), .CH_W(CH_W),
    .BIT_W(BIT_W), .ACQ_CYC(ACQ_CYC), .CONV_HI(CONV_HI),
    .NAP_PULSES(NAP_PULSES), .SLEEP_PULSES(SLEEP_PULSES)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .start   (start),
    .cfg_sel (cfg_sel),
    .cfg_bip (cfg_bip),
    .pd_req  (pd_req),
    .pd_deep (pd_deep),
    .nch     (nch),
    .conv    (adc_conv),
    .sck     (adc_sck),
    .samp    (samp),
    .bit_idx (bit_idx),
    .sel     (adc_sel),
    .bip     (adc_bip),
    .keep    (keep),
    .busy    (busy),
    .dozing  (dozing)
  );

  adc_ctl_capture #(
    .SLOT_W(SLOT_W), .RES_W(RES_W), .LEAD(LEAD), .OUT_W(OUT_W),
    .POS_W(POS_W), .CH_W(CH_W), .BIT_W(BIT_W)
  ) u_cap (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .samp      (samp),
    .sdo       (adc_sdo),
    .bit_idx   (bit_idx),
    .keep      (keep),
    .bip       (adc_bip),
    .res_valid (res_valid),
    .res_chan  (res_chan),
    .res_data  (res_data)
  );
endmodule

// File: rtl/adc_ctl_chk.sv
module adc_ctl_chk #(
  parameter int NCH     = 6,
  parameter int SEL_W   = 3,
  parameter int CH_W    = 3,
  parameter int OUT_W   = 16,
  parameter int RES_W   = 14,
  parameter int ACQ_CYC = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             dozing,
  input logic             adc_conv,
  input logic             adc_sck,
  input logic [SEL_W-1:0] adc_sel,
  input logic             adc_bip,
  input logic             res_valid,
  input logic [CH_W-1:0]  res_chan,
  input logic [OUT_W-1:0] res_data
);
  localparam int AW = $clog2(ACQ_CYC + 1);

  logic          bip_d;
  logic [AW-1:0] acq_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bip_d   <= 1'b0;
      acq_cnt <= AW'(ACQ_CYC);
    end else begin
      bip_d <= adc_bip;
      if (adc_bip != bip_d)            acq_cnt <= '0;
      else if (acq_cnt != AW'(ACQ_CYC)) acq_cnt <= acq_cnt + 1'b1;
    end
  end

  // R5
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(adc_sel) && $stable(adc_bip));

  // R2
  pins_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !adc_sck && !adc_conv);

  // R8
  conv_sck_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_conv |-> !adc_sck);

  // R8
  doze_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dozing |-> !busy && !adc_sck);

  // R1
  chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> 32'(res_chan) < NCH);

  // R7
  zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !adc_bip |-> res_data[OUT_W-1:RES_W] == '0);

  // R7
  sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && adc_bip |-> res_data[OUT_W-1:RES_W-1] == '0 || res_data[OUT_W-1:RES_W-1] == '1);

  // R6
  acq_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_conv) |-> 32'(acq_cnt) >= ACQ_CYC - 1);
endmodule

bind adc_ctl adc_ctl_chk #(
  .NCH(NCH), .SEL_W(SEL_W), .CH_W(CH_W), .OUT_W(OUT_W), .RES_W(RES_W), .ACQ_CYC(ACQ_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .dozing    (dozing),
  .adc_conv  (adc_conv),
  .adc_sck   (adc_sck),
  .adc_sel   (adc_sel),
  .adc_bip   (adc_bip),
  .res_valid (res_valid),
  .res_chan  (res_chan),
  .res_data  (res_data)
);

// File: tb/adc_ctl_bench.sv
`timescale 1ns/1ps
module adc_ctl_bench;
  localparam int ACQ = 20;
  localparam real TCK = 4.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  cfg_sel = 3'd0;
  logic        cfg_bip = 1'b0;
  logic        pd_req = 1'b0;
  logic        pd_deep = 1'b0;
  logic        busy, dozing, res_valid, adc_conv, adc_sck, adc_bip;
  logic [2:0]  res_chan, adc_sel;
  logic [15:0] res_data;
  logic        sdo_r = 1'b0;

  always #2 clk = ~clk;

  adc_ctl #(.ACQ_CYC(ACQ)) u_adc_ctl (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_sel(cfg_sel), .cfg_bip(cfg_bip),
    .pd_req(pd_req), .pd_deep(pd_deep), .busy(busy), .dozing(dozing),
    .res_valid(res_valid), .res_chan(res_chan), .res_data(res_data),
    .adc_conv(adc_conv), .adc_sck(adc_sck), .adc_sel(adc_sel), .adc_bip(adc_bip),
    .adc_sdo(sdo_r)
  );

  int vec = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [13:0] gen(input int k, input int ch);
    int v;
    v = (k * 2531 + ch * 4919 + 77) % 16384;
    if (k % 4 == 1) begin
      case (ch)
        0: v = 8192;
        1: v = 8191;
        2: v = 16383;
        3: v = 0;
        default: ;
      endcase
    end
    return 14'(v);
  endfunction

  function automatic logic [15:0] ext(input logic [13:0] v, input logic b);
    return b ? {{2{v[13]}}, v} : {2'b00, v};
  endfunction

  function automatic int nch_of(input int s);
    return (s >= 5) ? 6 : s + 1;
  endfunction

  // behavioural converter model
  int run_conv = 0, wake_cnt = 0, sck_cnt = 0, frames = 0, conv_idx = 0, bitpos = 0;
  int acq_err = 0, cfg_err = 0, wake_acq_err = 0;
  bit wake_pend = 0;
  logic [13:0] samp_cur [6];
  logic [13:0] out_buf [6];
  logic [2:0]  m_sel = 3'd0;
  logic        m_bip = 1'b0;
  realtime     t_bip = -1000.0, t_wake = -1000.0;

  initial for (int c = 0; c < 6; c++) begin samp_cur[c] = '0; out_buf[c] = '0; end

  always @(adc_bip) t_bip = $realtime;

  always @(posedge adc_conv) begin
    run_conv++;
    if (run_conv == 1) begin
      frames++;
      for (int c = 0; c < 6; c++) begin
        out_buf[c]  = samp_cur[c];
        samp_cur[c] = gen(conv_idx, c);
      end
      conv_idx++;
      bitpos  = 0;
      sck_cnt = 0;
      m_sel   = adc_sel;
      m_bip   = adc_bip;
      if ($realtime - t_bip < ACQ * TCK) acq_err++;
      if (wake_pend && ($realtime - t_wake < ACQ * TCK)) wake_acq_err++;
      wake_pend = 0;
    end
  end

  always @(posedge adc_sck) begin
    if (run_conv >= 2) begin
      wake_cnt++;
      t_wake    = $realtime;
      wake_pend = 1;
    end else begin
      logic [15:0] w;
      if (adc_sel !== m_sel || adc_bip !== m_bip) cfg_err++;
      w = (bitpos / 16 < 6) ? {2'b00, out_buf[bitpos / 16]} : 16'h0;
      sdo_r <= w[15 - bitpos % 16];
      bitpos++;
      sck_cnt++;
    end
    run_conv = 0;
  end

  // result monitor
  int got = 0;
  always @(negedge clk) begin
    if (res_valid) begin
      if (got < 6) begin
        // R1 ordering; R3 slot layout, R4 previous conversion, R7 extension
        chk(res_chan == 3'(got), "R1 channel", int'(res_chan), got);
        chk(res_data == ext(out_buf[got], m_bip), "R3/R4/R7 data",
            int'(res_data), int'(ext(out_buf[got], m_bip)));
      end
      got++;
    end
  end

  task automatic frame(input int s, input bit b, input bit expv);
    while (busy) @(negedge clk);
    got = 0;
    start = 1'b1; cfg_sel = 3'(s); cfg_bip = b;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(got == (expv ? nch_of(s) : 0), "R4 result count", got, expv ? nch_of(s) : 0);
    chk(sck_cnt == 16 * nch_of(s), "R2 sck per frame", sck_cnt, 16 * nch_of(s));
  endtask

  task automatic power_down(input bit deep);
    int rc;
    @(negedge clk);
    pd_req = 1'b1; pd_deep = deep;
    @(negedge clk);
    pd_req = 1'b0;
    while (!dozing) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(run_conv == (deep ? 4 : 2), "R8 pulse count", run_conv, deep ? 4 : 2);
    rc = run_conv;
    pd_req = 1'b1; pd_deep = ~deep;
    @(negedge clk);
    pd_req = 1'b0;
    repeat (20) @(negedge clk);
    chk(run_conv == rc && dozing, "R8 request while dozing", run_conv, rc);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    vec++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    int w0, f0;
    repeat (30) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !dozing && !res_valid, "R10 reset idle", int'(busy), 0);
    chk(!adc_conv && !adc_sck, "R2 reset pins", int'(adc_sck), 0);

    for (int s = 0; s < 8; s++) begin
      for (int b = 0; b < 2; b++) begin
        frame(s, b[0], 1'b0);
        frame(s, b[0], 1'b1);
      end
    end
    chk(acq_err == 0, "R6 acquisition gap", acq_err, 0);
    chk(cfg_err == 0, "R5 pins stable", cfg_err, 0);

    // R10: second start during a frame is ignored
    while (busy) @(negedge clk);
    f0 = frames; got = 0;
    start = 1'b1; cfg_sel = 3'd5; cfg_bip = 1'b0;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    start = 1'b1; cfg_sel = 3'd1; cfg_bip = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(frames == f0 + 1, "R10 frames started", frames - f0, 1);
    chk(adc_sel == 3'd5 && adc_bip == 1'b0, "R10 pins kept", int'(adc_sel), 5);
    frame(5, 1'b0, 1'b1);

    // light power-down then wake
    power_down(1'b0);
    w0 = wake_cnt;
    frame(2, 1'b0, 1'b0);
    chk(wake_cnt == w0 + 1, "R9 wake pulses", wake_cnt - w0, 1);
    chk(wake_acq_err == 0, "R9 wake gap", wake_acq_err, 0);
    frame(2, 1'b0, 1'b1);

    // deep power-down then wake with a range change
    power_down(1'b1);
    w0 = wake_cnt;
    frame(6, 1'b1, 1'b0);
    chk(wake_cnt == w0 + 1, "R9 wake pulses", wake_cnt - w0, 1);
    frame(6, 1'b1, 1'b1);
    frame(6, 1'b1, 1'b1);
    chk(acq_err == 0 && wake_acq_err == 0, "R6 gaps after wake", acq_err, 0);
    chk(cfg_err == 0, "R5 pins stable", cfg_err, 0);
    finish_run();
  end
endmodule